// File: doc/BRIEF.md
# Fully Associative Address Translation Lookup

The block holds a small set of translation entries and resolves a virtual address plus a 13-bit context to a 32-bit physical page address in one pass. Every entry pairs a 64-bit tag with a 64-bit translation word. Each translation word carries its own page size, and that size sets how many low virtual address bits take part in the compare. All entries are compared in parallel and the lowest-numbered match is used.

A lookup request is resolved combinationally and the result is registered, so it appears on the outputs one clock after the request. A hit that breaks a protection rule returns a fault, not a hit. When no entry matches, the block also returns a fault, flagged as a miss. The fault kind is instruction-side or data-side, and a parameter chooses the variant. When translation is switched off, the address passes straight through with full rights. Software or a refill engine loads entries through a one-entry-per-cycle write port. Replacement and demapping are handled outside the block.

Top module: `xlat_cam`

## Requirements
- R1: After reset every entry is invalid, and `rsp_valid_o`, `hit_o`, `fault_o`, `miss_o`, `fault_data_o`, `can_write_o` and `pa_o` are all zero.
- R2: A request on `lookup_i` sampled at a rising edge sets `rsp_valid_o` and the result outputs after that edge. In a cycle with no request, all result outputs are zero.
- R3: An entry whose translation word bit 63 is clear never matches.
- R4: Translation word bits [62:61] select the page size: 0 = 8 KB, 1 = 64 KB, 2 = 512 KB, 3 = 4 MB. Virtual address bits [63:13], [63:16], [63:19] or [63:22] take part in the compare, and all lower bits are ignored.
- R5: A match requires `ctx_i` to equal tag bits [12:0], and the masked virtual address to equal the tag with bits [12:0] cleared. A tag bit set below the page boundary therefore prevents any match.
- R6: On a hit, `pa_o` equals translation word bits [31:13] followed by 13 zero bits.
- R7: When several entries match, the entry with the lowest index supplies the result.
- R8: A match on an entry with translation word bit 2 set while `priv_i` is low gives `fault_o`=1, `hit_o`=0, `miss_o`=0, `can_write_o`=0 and `pa_o`=0.
- R9: In the data variant, a match with `write_i` high on an entry whose bit 1 is clear faults, in the same way as R8. The instruction variant ignores both `write_i` and bit 1 when deciding a fault.
- R10: On a hit, `can_write_o` equals translation word bit 1 in the data variant and is 0 in the instruction variant.
- R11: With `xlat_en_i` low, the result is `hit_o`=1, `can_write_o`=1, no fault, and `pa_o` = `va_i[31:0]`, whatever the entries hold.
- R12: With translation on and no matching entry, the result is `fault_o`=1 and `miss_o`=1. In every fault, `fault_data_o` is 1 in the data variant and 0 in the instruction variant.
- R13: A write through `wr_en_i` replaces the tag and translation word at `wr_idx_i`. A lookup in the same cycle still sees the old contents, and lookups from the next cycle on see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | $clog2(ENTRIES) | Entry index to write |
| wr_tag_i | input | 64 | Tag to store: VA page bits [63:13], context [12:0] |
| wr_tte_i | input | 64 | Translation word to store |
| lookup_i | input | 1 | Lookup request |
| xlat_en_i | input | 1 | Translation enable; low selects pass-through |
| va_i | input | 64 | Virtual address |
| ctx_i | input | 13 | Current context |
| priv_i | input | 1 | Requester is privileged |
| write_i | input | 1 | Access is a store |
| rsp_valid_o | output | 1 | Registered result is valid |
| hit_o | output | 1 | Translation succeeded |
| fault_o | output | 1 | Miss or protection fault |
| miss_o | output | 1 | Fault caused by no matching entry |
| fault_data_o | output | 1 | Fault is of data kind (else instruction kind) |
| can_write_o | output | 1 | Store permitted on this page |
| pa_o | output | PA_W | Physical address |

## Verification
The hardest case to reach from the ports is the exact boundary of each page-size mask. The stimulus loads one entry at a 4 MB aligned base and then flips each virtual address bit from 0 to 39 in turn, once for each of the four sizes. A flip hits exactly when the bit lies below the page boundary. Priority is driven by loading every entry with the same tag and then invalidating entries one at a time from the bottom, so each index gets a turn as the winner. A write and a lookup to the same entry in one cycle exercises the old-contents rule.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
  localparam int unsigned TAG_W = 64;
  localparam int unsigned TTE_W = 64;
  localparam int unsigned CTX_W = 13;
  localparam int unsigned OFS_W = 13;

  localparam int unsigned TTE_VLD   = 63;
  localparam int unsigned TTE_SZ_HI = 62;
  localparam int unsigned TTE_SZ_LO = 61;
  localparam int unsigned TTE_PRV   = 2;
  localparam int unsigned TTE_WRT   = 1;

  typedef logic [TAG_W-1:0] tag_t;
  typedef logic [TTE_W-1:0] tte_t;

  typedef enum logic [1:0] {PG_8K, PG_64K, PG_512K, PG_4M} pg_size_e;

  typedef struct packed {
    logic hit;
    logic fault;
    logic miss;
    logic can_wr;
  } verdict_t;

  function automatic tag_t va_mask(pg_size_e sz);
    case (sz)
      PG_8K:   return ~tag_t'(64'h1fff);
      PG_64K:  return ~tag_t'(64'hffff);
      PG_512K: return ~tag_t'(64'h7ffff);
      default: return ~tag_t'(64'h3fffff);
    endcase
  endfunction
endpackage

// File: rtl/xlat_store.sv
`timescale 1ns/1ps
module xlat_store
  import xlat_pkg::*;
#(
  parameter int unsigned ENTRIES = 64
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx_i,
  input  tag_t                       wr_tag_i,
  input  tte_t                       wr_tte_i,
  output tag_t                       tag_o [ENTRIES],
  output tte_t                       tte_o [ENTRIES]
);
  tag_t tag_q [ENTRIES];
  tte_t tte_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(ENTRIES); i++) begin
        tag_q[i] <= '0;
        tte_q[i] <= '0;
      end
    end else if (wr_en_i) begin
      tag_q[wr_idx_i] <= wr_tag_i;
      tte_q[wr_idx_i] <= wr_tte_i;
    end
  end

  assign tag_o = tag_q;
  assign tte_o = tte_q;
endmodule

// File: rtl/xlat_match.sv
`timescale 1ns/1ps
module xlat_match
  import xlat_pkg::*;
#(
  parameter int unsigned ENTRIES = 64
) (
  input  tag_t               tag_i [ENTRIES],
  input  tte_t               tte_i [ENTRIES],
  input  tag_t               va_i,
  input  logic [CTX_W-1:0]   ctx_i,
  output logic [ENTRIES-1:0] match_o
);
  localparam tag_t PAGE_CLR = ~tag_t'((64'd1 << OFS_W) - 64'd1);

  for (genvar g = 0; g < int'(ENTRIES); g++) begin : g_ent
    tag_t msk;
    logic ctx_eq, va_eq;
    assign msk    = va_mask(pg_size_e'(tte_i[g][TTE_SZ_HI:TTE_SZ_LO]));
    assign ctx_eq = tag_i[g][CTX_W-1:0] == ctx_i;
    assign va_eq  = (va_i & msk) == (tag_i[g] & PAGE_CLR);
    assign match_o[g] = tte_i[g][TTE_VLD] && ctx_eq && va_eq;
  end
endmodule

// File: rtl/xlat_pick.sv
`timescale 1ns/1ps
module xlat_pick #(
  parameter int unsigned ENTRIES = 64
) (
  input  logic [ENTRIES-1:0]         req_i,
  output logic                       any_o,
  output logic [$clog2(ENTRIES)-1:0] idx_o
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  // scan downward so the lowest set index is written last
  always_comb begin
    idx_o = '0;
    for (int i = int'(ENTRIES) - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/xlat_cam.sv
`timescale 1ns/1ps
module xlat_cam
  import xlat_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  parameter bit          IS_DATA = 1'b1,
  parameter int unsigned PA_W    = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx_i,
  input  logic [63:0]                wr_tag_i,
  input  logic [63:0]                wr_tte_i,
  input  logic                       lookup_i,
  input  logic                       xlat_en_i,
  input  logic [63:0]                va_i,
  input  logic [12:0]                ctx_i,
  input  logic                       priv_i,
  input  logic                       write_i,
  output logic                       rsp_valid_o,
  output logic                       hit_o,
  output logic                       fault_o,
  output logic                       miss_o,
  output logic                       fault_data_o,
  output logic                       can_write_o,
  output logic [PA_W-1:0]            pa_o
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  tag_t               tag_arr [ENTRIES];
  tte_t               tte_arr [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic               any_match;
  logic [IDX_W-1:0]   sel_idx;
  tte_t               sel_tte;
  verdict_t           vd;
  logic [PA_W-1:0]    pa_d;
  logic               prv_flt, wr_flt;

  xlat_store #(.ENTRIES(ENTRIES)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_idx_i (wr_idx_i),
    .wr_tag_i (wr_tag_i),
    .wr_tte_i (wr_tte_i),
    .tag_o    (tag_arr),
    .tte_o    (tte_arr)
  );

  xlat_match #(.ENTRIES(ENTRIES)) u_match (
    .tag_i   (tag_arr),
    .tte_i   (tte_arr),
    .va_i    (va_i),
    .ctx_i   (ctx_i),
    .match_o (match)
  );

  xlat_pick #(.ENTRIES(ENTRIES)) u_pick (
    .req_i (match),
    .any_o (any_match),
    .idx_o (sel_idx)
  );

  assign sel_tte = tte_arr[sel_idx];
  assign prv_flt = sel_tte[TTE_PRV] && !priv_i;
  assign wr_flt  = IS_DATA && write_i && !sel_tte[TTE_WRT];

  always_comb begin
    vd   = '0;
    pa_d = '0;
    if (!xlat_en_i) begin
      vd.hit    = 1'b1;
      vd.can_wr = 1'b1;
      pa_d      = va_i[PA_W-1:0];
    end else if (!any_match) begin
      vd.fault = 1'b1;
      vd.miss  = 1'b1;
    end else if (prv_flt || wr_flt) begin
      vd.fault = 1'b1;
    end else begin
      vd.hit    = 1'b1;
      vd.can_wr = IS_DATA && sel_tte[TTE_WRT];
      pa_d      = {sel_tte[PA_W-1:OFS_W], {OFS_W{1'b0}}};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      hit_o        <= 1'b0;
      fault_o      <= 1'b0;
      miss_o       <= 1'b0;
      fault_data_o <= 1'b0;
      can_write_o  <= 1'b0;
      pa_o         <= '0;
    end else if (lookup_i) begin
      rsp_valid_o  <= 1'b1;
      hit_o        <= vd.hit;
      fault_o      <= vd.fault;
      miss_o       <= vd.miss;
      fault_data_o <= vd.fault && IS_DATA;
      can_write_o  <= vd.can_wr;
      pa_o         <= pa_d;
    end else begin
      rsp_valid_o  <= 1'b0;
      hit_o        <= 1'b0;
      fault_o      <= 1'b0;
      miss_o       <= 1'b0;
      fault_data_o <= 1'b0;
      can_write_o  <= 1'b0;
      pa_o         <= '0;
    end
  end
endmodule

// File: rtl/xlat_cam_chk.sv
`timescale 1ns/1ps
module xlat_cam_chk #(
  parameter bit          IS_DATA = 1'b1,
  parameter int unsigned PA_W    = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            lookup_i,
  input logic            xlat_en_i,
  input logic [63:0]     va_i,
  input logic            rsp_valid_o,
  input logic            hit_o,
  input logic            fault_o,
  input logic            miss_o,
  input logic            fault_data_o,
  input logic            can_write_o,
  input logic [PA_W-1:0] pa_o
);
  // R2
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_i |=> rsp_valid_o);

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_i |=> (!rsp_valid_o && !hit_o && !fault_o && !miss_o && !can_write_o));

  // R11
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_i && !xlat_en_i) |=>
      (hit_o && !fault_o && can_write_o && pa_o == $past(va_i[PA_W-1:0])));

  // R6
  pa_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_i && xlat_en_i) |=> (!hit_o || pa_o[12:0] == 13'd0));

  // R12
  miss_is_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (fault_o && !hit_o));

  // R12
  fault_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (fault_data_o == IS_DATA));

  // R8
  fault_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!hit_o && !can_write_o && pa_o == '0));
endmodule

bind xlat_cam xlat_cam_chk #(.IS_DATA(IS_DATA), .PA_W(PA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lookup_i     (lookup_i),
  .xlat_en_i    (xlat_en_i),
  .va_i         (va_i),
  .rsp_valid_o  (rsp_valid_o),
  .hit_o        (hit_o),
  .fault_o      (fault_o),
  .miss_o       (miss_o),
  .fault_data_o (fault_data_o),
  .can_write_o  (can_write_o),
  .pa_o         (pa_o)
);

// File: tb/xlat_cam_bench.sv
`timescale 1ns/1ps
module xlat_cam_bench;
  localparam int N  = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic          wr_en, lookup, xlat_en, priv, wr;
  logic [IW-1:0] wr_idx;
  logic [63:0]   wr_tag, wr_tte, va;
  logic [12:0]   ctx;

  logic d_vld, d_hit, d_flt, d_miss, d_fd, d_cw;
  logic i_vld, i_hit, i_flt, i_miss, i_fd, i_cw;
  logic [31:0] d_pa, i_pa;

  int total = 0;
  int bad   = 0;
  logic [63:0] m_tag [N];
  logic [63:0] m_tte [N];

  xlat_cam #(.ENTRIES(N), .IS_DATA(1'b1), .PA_W(32)) u_xlat_cam (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_tag_i(wr_tag), .wr_tte_i(wr_tte), .lookup_i(lookup), .xlat_en_i(xlat_en),
    .va_i(va), .ctx_i(ctx), .priv_i(priv), .write_i(wr),
    .rsp_valid_o(d_vld), .hit_o(d_hit), .fault_o(d_flt), .miss_o(d_miss),
    .fault_data_o(d_fd), .can_write_o(d_cw), .pa_o(d_pa));

  xlat_cam #(.ENTRIES(N), .IS_DATA(1'b0), .PA_W(32)) u_xlat_cam_ins (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_tag_i(wr_tag), .wr_tte_i(wr_tte), .lookup_i(lookup), .xlat_en_i(xlat_en),
    .va_i(va), .ctx_i(ctx), .priv_i(priv), .write_i(wr),
    .rsp_valid_o(i_vld), .hit_o(i_hit), .fault_o(i_flt), .miss_o(i_miss),
    .fault_data_o(i_fd), .can_write_o(i_cw), .pa_o(i_pa));

  // packed result: {valid, hit, fault, miss, fault_data, can_write, pa[31:0]}
  function automatic logic [37:0] model(bit ds, logic [63:0] a, logic [12:0] c,
                                        bit pv, bit w, bit en);
    int shamt;
    logic [63:0] msk;
    logic [63:0] t;
    if (!en) return {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, a[31:0]};
    for (int i = 0; i < N; i++) begin
      t = m_tte[i];
      if (t[63]) begin
        shamt = 13 + 3 * int'(t[62:61]);
        msk = ~64'd0 << shamt;
        if (c == m_tag[i][12:0] && (a & msk) == (m_tag[i] & ~64'h1fff)) begin
          if ((t[2] && !pv) || (ds && w && !t[1]))
            return {1'b1, 1'b0, 1'b1, 1'b0, ds, 1'b0, 32'd0};
          return {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, ds & t[1], t[31:13], 13'd0};
        end
      end
    end
    return {1'b1, 1'b0, 1'b1, 1'b1, ds, 1'b0, 32'd0};
  endfunction

  function automatic logic [63:0] mk_tte(bit v, logic [1:0] sz, logic [18:0] pfn,
                                         bit pr, bit w);
    logic [63:0] t;
    t = '0;
    t[63] = v; t[62:61] = sz; t[31:13] = pfn; t[2] = pr; t[1] = w;
    return t;
  endfunction

  function automatic logic [37:0] d_out();
    return {d_vld, d_hit, d_flt, d_miss, d_fd, d_cw, d_pa};
  endfunction
  function automatic logic [37:0] i_out();
    return {i_vld, i_hit, i_flt, i_miss, i_fd, i_cw, i_pa};
  endfunction

  task automatic check(string req, logic [37:0] act, logic [37:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_ent(int idx, logic [63:0] tg, logic [63:0] te);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_tag = tg; wr_tte = te;
    m_tag[idx] = tg; m_tte[idx] = te;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(string req, logic [63:0] a, logic [12:0] c, bit pv, bit w, bit en);
    logic [37:0] ed, ei;
    @(negedge clk);
    lookup = 1'b1; va = a; ctx = c; priv = pv; wr = w; xlat_en = en;
    ed = model(1'b1, a, c, pv, w, en);
    ei = model(1'b0, a, c, pv, w, en);
    @(negedge clk);
    lookup = 1'b0;
    check({req, " data"}, d_out(), ed);
    check({req, " instr"}, i_out(), ei);
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) wr_ent(i, 64'd0, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R2 watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] base;
    logic [12:0] cx;
    logic [37:0] ed;
    for (int i = 0; i < N; i++) begin m_tag[i] = '0; m_tte[i] = '0; end
    rst_n = 1'b0; wr_en = 0; lookup = 0; xlat_en = 1; priv = 0; wr = 0;
    wr_idx = '0; wr_tag = '0; wr_tte = '0; va = '0; ctx = '0;
    repeat (3) @(negedge clk);
    check("R1 reset data", d_out(), 38'd0);
    check("R1 reset instr", i_out(), 38'd0);
    rst_n = 1'b1;

    // R1 R12: empty table misses
    look("R1 R12 empty", 64'h0, 13'd0, 1'b1, 1'b0, 1'b1);
    look("R12 empty", 64'hdead_beef_0000_2000, 13'h1ff, 1'b0, 1'b1, 1'b1);

    // R2: idle cycle yields zeros
    @(negedge clk);
    check("R2 idle data", d_out(), 38'd0);
    check("R2 idle instr", i_out(), 38'd0);

    // R11: bypass
    look("R11 bypass", 64'h0123_4567_89ab_cdef, 13'h3, 1'b0, 1'b1, 1'b0);
    look("R11 bypass", 64'hffff_ffff_ffff_ffff, 13'h0, 1'b0, 1'b0, 1'b0);

    // R4 R6: per-size mask sweep
    base = 64'h0000_1234_5640_0000;
    cx   = 13'h0a5;
    for (int sz = 0; sz < 4; sz++) begin
      wr_ent(0, {base[63:13], cx}, mk_tte(1'b1, 2'(sz), 19'h2a5a5, 1'b0, 1'b1));
      for (int b = 0; b < 40; b++)
        look("R4 R6 mask", base ^ (64'd1 << b), cx, 1'b1, 1'b0, 1'b1);
    end

    // R11: bypass ignores loaded entries
    look("R11 bypass loaded", base, cx, 1'b0, 1'b1, 1'b0);

    // R5: context compare and tag bits below the page boundary
    wr_ent(0, {base[63:13], cx}, mk_tte(1'b1, 2'd0, 19'h11111, 1'b0, 1'b1));
    for (int b = 0; b < 13; b++)
      look("R5 ctx", base, cx ^ 13'(1 << b), 1'b1, 1'b0, 1'b1);
    wr_ent(0, {base[63:13], cx} | (64'd1 << 14), mk_tte(1'b1, 2'd1, 19'h11111, 1'b0, 1'b1));
    look("R5 low tag bit", base | (64'd1 << 14), cx, 1'b1, 1'b0, 1'b1);
    look("R5 low tag bit", base, cx, 1'b1, 1'b0, 1'b1);

    // R3: valid bit clear
    wr_ent(0, {base[63:13], cx}, mk_tte(1'b0, 2'd0, 19'h11111, 1'b0, 1'b1));
    look("R3 invalid", base, cx, 1'b1, 1'b0, 1'b1);

    // R7: priority, invalidating from the bottom
    for (int i = 0; i < N; i++)
      wr_ent(i, {base[63:13], cx}, mk_tte(1'b1, 2'(i % 4), 19'(i + 1), 1'b0, 1'b1));
    for (int k = 0; k < N; k++) begin
      look("R7 priority", base, cx, 1'b1, 1'b0, 1'b1);
      wr_ent(k, 64'd0, 64'd0);
    end
    look("R7 all gone", base, cx, 1'b1, 1'b0, 1'b1);

    // R8 R9 R10: exhaustive protection combinations
    for (int pr = 0; pr < 2; pr++)
      for (int wb = 0; wb < 2; wb++) begin
        wr_ent(3, {base[63:13], cx}, mk_tte(1'b1, 2'd2, 19'h7abcd, pr[0], wb[0]));
        for (int pv = 0; pv < 2; pv++)
          for (int w = 0; w < 2; w++)
            look("R8 R9 R10 prot", base | 64'h1_2345, cx, pv[0], w[0], 1'b1);
      end

    // R13: write and lookup in the same cycle
    clear_all();
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd5; wr_tag = {base[63:13], cx};
    wr_tte = mk_tte(1'b1, 2'd3, 19'h0beef, 1'b0, 1'b1);
    lookup = 1'b1; va = base; ctx = cx; priv = 1'b1; wr = 1'b0; xlat_en = 1'b1;
    ed = model(1'b1, base, cx, 1'b1, 1'b0, 1'b1);
    m_tag[5] = wr_tag; m_tte[5] = wr_tte;
    @(negedge clk);
    wr_en = 1'b0; lookup = 1'b0;
    check("R13 same cycle old", d_out(), ed);
    look("R13 next cycle new", base, cx, 1'b1, 1'b0, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule